// File: doc/BRIEF.md
# Programmable Interrupt Input Controller

This block gathers external interrupt requests from three kinds of pin: an eight-line keyboard row group, a pen-down input and four general-purpose request pins. Every pin is individually switched between plain parallel input and interrupt duty. Pins in input duty can be read through a data register and never raise a request. Pins in interrupt duty are conditioned by their programmed trigger rule and feed a set of pending bits.

The four general pins each pick edge or level triggering and active-high or active-low polarity. They request fixed CPU priority levels 6, 3, 2 and 1. The keyboard group is active-low: any enabled row line pulled low raises one keyboard request. The pen input is an active-low level request. The keyboard and pen priority levels are programmable. A per-source mask keeps a pending request off the output without clearing it. The registered output carries the highest unmasked pending level, with a request flag beside it.

Software uses a small register file: pin function, trigger mode and polarity, mask, pending status with write-one-to-clear, the keyboard and pen levels, and the pin data view. Sources in the pending, mask and output logic are indexed 0 keyboard, 1 pen, 2 to 5 general pins 0 to 3.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the FUNC (addr 0), TRIG (addr 1), MASK (addr 2) and PEND (addr 3) registers read 0, PRIO (addr 4) reads 0x0044, and `irq_level` and `irq_req` are 0.
- R2: FUNC bits [7:0] enable keyboard lines, bit 8 the pen input and bits [12:9] general pins 0 to 3 for interrupt duty (1 = interrupt). A pin with its FUNC bit at 0 never raises a request. DATA (addr 5) shows its synchronized value in the same bit position, and shows 0 for pins in interrupt duty.
- R3: A general pin in level mode (TRIG bit i = 0) is pending exactly while its input equals the polarity in TRIG bit 4+i (1 = active high), and stops pending when the input goes inactive.
- R4: A general pin in edge mode (TRIG bit i = 1) sets a sticky pending bit on its inactive-to-active transition, and the bit stays set after the input returns inactive.
- R5: Writing PEND with a 1 in bit 2+i clears the sticky bit of general pin i. Writing 0 leaves it set. A new edge in the same cycle as the clear wins.
- R6: General pins 0, 1, 2 and 3 request levels 6, 3, 2 and 1.
- R7: The keyboard source (PEND bit 0) is pending while any keyboard line enabled in FUNC is low, and lines in input duty are ignored. It requests the level in PRIO bits [2:0]. Level 0 never raises the output.
- R8: The pen source (PEND bit 1) is pending while the pen input is enabled and low. It requests the level in PRIO bits [6:4].
- R9: A MASK bit set to 1 keeps that source off the output, while its PEND bit still reads 1.
- R10: `irq_level` is the highest level among unmasked pending sources, or 0 when there are none. `irq_req` is 1 exactly when `irq_level` is nonzero.
- R11: Inputs pass through a two-flop synchronizer and the output is registered. A level change on a pin reaches `irq_level` within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| kb_row | input | 8 | Keyboard row lines, idle high |
| pen_down_n | input | 1 | Pen-down input, active low |
| gp_pin | input | 4 | General interrupt pins 0 to 3 |
| irq_level | output | 3 | Highest unmasked pending priority level |
| irq_req | output | 1 | Interrupt request, high when the level is nonzero |

## Verification
The bench sweeps every general pin through all four combinations of trigger mode and polarity. A swapped polarity or a missing sticky latch shows up as a wrong level after the input falls back to inactive. All 64 mask patterns are applied with every source pending, and all 16 subsets of general pins with nothing else in play. An arbiter that picked by index instead of level, or read the non-contiguous level map wrongly, would report the wrong maximum in these sweeps. The bench also checks that a written zero does not clear a sticky bit, that a keyboard line in input duty raises nothing while a low line in interrupt duty does, and that a masked source still reads pending.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef logic [2:0] lvl_t;

  localparam int ADR_FUNC = 0;
  localparam int ADR_TRIG = 1;
  localparam int ADR_MASK = 2;
  localparam int ADR_PEND = 3;
  localparam int ADR_PRIO = 4;
  localparam int ADR_DATA = 5;

  localparam lvl_t KB_LVL_RST  = 3'd4;
  localparam lvl_t PEN_LVL_RST = 3'd4;

  // fixed CPU level wired to each general request pin
  function automatic lvl_t gp_fixed_level(input int idx);
    case (idx)
      0:       return 3'd6;
      1:       return 3'd3;
      2:       return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // pin value seen through the programmed polarity
  function automatic logic cond_active(input logic v, input logic act_high);
    return act_high ? v : ~v;
  endfunction

  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) st[s] <= RST_VAL;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pin_irq_gp_src.sv
module pin_irq_gp_src
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic int_en,
  input  logic edge_mode,
  input  logic active_high,
  input  logic clr,
  output logic pend,
  output logic sticky,
  output logic edge_evt
);
  logic cond, cond_prev, armed;

  assign cond     = cond_active(pin_s, active_high);
  assign armed    = int_en & edge_mode;
  assign edge_evt = armed & cond & ~cond_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_prev <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      cond_prev <= cond;
      if (!armed)        sticky <= 1'b0;
      else if (edge_evt) sticky <= 1'b1;
      else if (clr)      sticky <= 1'b0;
    end
  end

  assign pend = int_en & (edge_mode ? sticky : cond);
endmodule

// File: rtl/pin_irq_prio.sv
module pin_irq_prio
  import pin_irq_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N*3-1:0] lvl_flat,
  input  logic [N-1:0]   req,
  output lvl_t           top_lvl
);
  always_comb begin
    top_lvl = 3'd0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) top_lvl = lvl_max(top_lvl, lvl_flat[i*3 +: 3]);
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int KB_W = 8,
  parameter int GP_N = 4,
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [KB_W-1:0] kb_row,
  input  logic            pen_down_n,
  input  logic [GP_N-1:0] gp_pin,
  output logic [2:0]      irq_level,
  output logic            irq_req
);
  localparam int NSRC   = 2 + GP_N;
  localparam int FUNC_W = KB_W + 1 + GP_N;
  localparam int TRIG_W = 2 * GP_N;
  localparam logic [AW-1:0] A_FUNC = AW'(ADR_FUNC);
  localparam logic [AW-1:0] A_TRIG = AW'(ADR_TRIG);
  localparam logic [AW-1:0] A_MASK = AW'(ADR_MASK);
  localparam logic [AW-1:0] A_PEND = AW'(ADR_PEND);
  localparam logic [AW-1:0] A_PRIO = AW'(ADR_PRIO);
  localparam logic [AW-1:0] A_DATA = AW'(ADR_DATA);

  // configuration registers
  logic [FUNC_W-1:0] func_q;
  logic [TRIG_W-1:0] trig_q;
  logic [NSRC-1:0]   mask_q;
  lvl_t              kb_lvl_q, pen_lvl_q;
  lvl_t              irq_level_q;

  // synchronized pins
  logic [KB_W-1:0] kb_s;
  logic            pen_s;
  logic [GP_N-1:0] gp_s;

  // named internal events
  logic [KB_W-1:0] kb_en;
  logic            pen_en;
  logic [GP_N-1:0] gp_en, gp_pend, gp_sticky, gp_evt, gp_arm, gp_clr;
  logic            kb_pend, pen_pend;
  logic [NSRC-1:0] src_pend, eff_pend, w1c_bits;
  logic [NSRC*3-1:0] lvl_flat;
  lvl_t            top_lvl;
  logic [FUNC_W-1:0] io_view;

  pin_irq_sync #(.W(KB_W), .STAGES(SYNC_STAGES), .RST_VAL({KB_W{1'b1}})) u_sync_kb (
    .clk(clk), .rst_n(rst_n), .d(kb_row), .q(kb_s));
  pin_irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pen (
    .clk(clk), .rst_n(rst_n), .d(pen_down_n), .q(pen_s));
  pin_irq_sync #(.W(GP_N), .STAGES(SYNC_STAGES), .RST_VAL({GP_N{1'b0}})) u_sync_gp (
    .clk(clk), .rst_n(rst_n), .d(gp_pin), .q(gp_s));

  assign kb_en  = func_q[KB_W-1:0];
  assign pen_en = func_q[KB_W];
  assign gp_en  = func_q[KB_W+1 +: GP_N];
  assign gp_arm = gp_en & trig_q[GP_N-1:0];

  assign w1c_bits = (reg_we && reg_addr == A_PEND) ? reg_wdata[NSRC-1:0] : '0;
  assign gp_clr   = w1c_bits[2 +: GP_N];

  // keyboard: any enabled row pulled low; pen: enabled and low
  assign kb_pend  = |(kb_en & ~kb_s);
  assign pen_pend = pen_en & ~pen_s;

  for (genvar g = 0; g < GP_N; g++) begin : g_gp
    pin_irq_gp_src u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (gp_s[g]),
      .int_en     (gp_en[g]),
      .edge_mode  (trig_q[g]),
      .active_high(trig_q[GP_N+g]),
      .clr        (gp_clr[g]),
      .pend       (gp_pend[g]),
      .sticky     (gp_sticky[g]),
      .edge_evt   (gp_evt[g])
    );
    assign lvl_flat[(2+g)*3 +: 3] = gp_fixed_level(g);
  end

  assign lvl_flat[2:0] = kb_lvl_q;
  assign lvl_flat[5:3] = pen_lvl_q;

  assign src_pend = {gp_pend, pen_pend, kb_pend};
  assign eff_pend = src_pend & ~mask_q;

  pin_irq_prio #(.N(NSRC)) u_prio (
    .lvl_flat(lvl_flat), .req(eff_pend), .top_lvl(top_lvl));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_level_q <= 3'd0;
    else        irq_level_q <= top_lvl;
  end

  assign irq_level = irq_level_q;
  assign irq_req   = (irq_level_q != 3'd0);

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q    <= '0;
      trig_q    <= '0;
      mask_q    <= '0;
      kb_lvl_q  <= KB_LVL_RST;
      pen_lvl_q <= PEN_LVL_RST;
    end else if (reg_we) begin
      case (reg_addr)
        A_FUNC: func_q <= reg_wdata[FUNC_W-1:0];
        A_TRIG: trig_q <= reg_wdata[TRIG_W-1:0];
        A_MASK: mask_q <= reg_wdata[NSRC-1:0];
        A_PRIO: begin
          kb_lvl_q  <= reg_wdata[2:0];
          pen_lvl_q <= reg_wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  // pins in input duty show their value; interrupt pins read 0
  assign io_view = {gp_s, pen_s, kb_s} & ~func_q;

  always_comb begin
    case (reg_addr)
      A_FUNC:  reg_rdata = DW'(func_q);
      A_TRIG:  reg_rdata = DW'(trig_q);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_PEND:  reg_rdata = DW'(src_pend);
      A_PRIO:  reg_rdata = DW'({1'b0, pen_lvl_q, 1'b0, kb_lvl_q});
      A_DATA:  reg_rdata = DW'(io_view);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int GP_N = 4,
  parameter int FUNC_W = 13,
  parameter int NSRC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FUNC_W-1:0] func_q,
  input logic [2:0]        irq_level,
  input logic [NSRC-1:0]   eff_pend,
  input logic [GP_N-1:0]   gp_sticky,
  input logic [GP_N-1:0]   gp_arm,
  input logic [GP_N-1:0]   gp_clr,
  input logic [GP_N-1:0]   gp_evt
);
  logic [GP_N-1:0] hold_set;
  logic [GP_N-1:0] clr_only;
  assign hold_set = gp_sticky & gp_arm & ~gp_clr;
  assign clr_only = gp_clr & ~gp_evt;

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_pend == '0) |=> (irq_level == 3'd0));

  assert_level_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> ($past(eff_pend) != '0));

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gp_sticky & $past(hold_set)) == $past(hold_set)));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gp_sticky & $past(clr_only)) == '0));

  assert_io_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q == '0 && $past(func_q) == '0 && $past(func_q, 2) == '0) |-> (irq_level == 3'd0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.GP_N(GP_N), .FUNC_W(FUNC_W), .NSRC(NSRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .func_q(func_q), .irq_level(irq_level),
  .eff_pend(eff_pend), .gp_sticky(gp_sticky), .gp_arm(gp_arm),
  .gp_clr(gp_clr), .gp_evt(gp_evt));

// File: tb/test_pin_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [7:0]  kb_row = 8'hFF;
  logic        pen_down_n = 1'b1;
  logic [3:0]  gp_pin = 4'h0;
  logic [2:0]  irq_level;
  logic        irq_req;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int gp_lv [4] = '{6, 3, 2, 1};

  always #10 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kb_row(kb_row),
    .pen_down_n(pen_down_n), .gp_pin(gp_pin), .irq_level(irq_level),
    .irq_req(irq_req));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic chk_out(input string req, input int lvl);
    check(req, int'(irq_level), lvl);
    check(req, int'(irq_req), (lvl != 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rd(0, v); check("R1 func", v, 0);
    rd(1, v); check("R1 trig", v, 0);
    rd(2, v); check("R1 mask", v, 0);
    rd(3, v); check("R1 pend", v, 0);
    rd(4, v); check("R1 prio", v, 'h44);
    chk_out("R1 output", 0);
    rd(5, v); check("R2 data reset", v, 'h01FF);

    // R2 input duty: data view, no request
    kb_row = 8'h5A; gp_pin = 4'hA; pen_down_n = 1'b0;
    tick(4);
    rd(5, v); check("R2 data io", v, (4'hA << 9) | (0 << 8) | 8'h5A);
    chk_out("R2 io quiet", 0);
    rd(3, v); check("R2 io pend", v, 0);

    // R7 keyboard: lines 0..3 enabled, line 0 low
    wr(0, 'h000F);
    tick(4);
    rd(5, v); check("R2 data masked by func", v, (4'hA << 9) | 8'h50);
    rd(3, v); check("R7 kb pend", v, 1);
    chk_out("R7 kb level", 4);
    // enabled lines high, low lines in input duty are ignored
    kb_row = 8'h0F;
    tick(4);
    chk_out("R7 io lines ignored", 0);
    kb_row = 8'h0E;
    tick(4);
    chk_out("R11 kb line low within 4 cycles", 4);
    wr(4, 'h0040);
    tick(3);
    rd(3, v); check("R7 level 0 still pending", v, 1);
    chk_out("R7 level 0 silent", 0);
    wr(4, 'h0044);
    kb_row = 8'hFF; pen_down_n = 1'b1; gp_pin = 4'h0;
    wr(0, 0);
    tick(4);

    // R8 pen
    wr(0, 'h0100);
    tick(3);
    chk_out("R8 pen idle", 0);
    pen_down_n = 1'b0;
    tick(4);
    chk_out("R8 pen down", 4);
    rd(3, v); check("R8 pen pend", v, 2);
    wr(4, 'h0024);
    tick(3);
    chk_out("R8 pen level prog", 2);
    pen_down_n = 1'b1;
    tick(4);
    chk_out("R8 pen up", 0);
    wr(0, 0);

    // R3 R4 R5 R6 general pin sweep
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 2; p++) begin
          wr(0, 0);
          gp_pin[i] = ~p[0];
          tick(4);
          wr(1, (e << i) | (p << (4 + i)));
          wr(0, 1 << (9 + i));
          tick(4);
          chk_out($sformatf("R3 gp%0d e%0d p%0d inactive", i, e, p), 0);
          gp_pin[i] = p[0];
          tick(4);
          chk_out($sformatf("R6 gp%0d e%0d p%0d active", i, e, p), gp_lv[i]);
          rd(3, v); check("R3 pend bit", v, 1 << (2 + i));
          gp_pin[i] = ~p[0];
          tick(4);
          if (e == 1) begin
            chk_out($sformatf("R4 gp%0d p%0d sticky", i, p), gp_lv[i]);
            wr(3, 0);
            tick(2);
            chk_out("R5 zero write keeps", gp_lv[i]);
            wr(3, 1 << (2 + i));
            tick(2);
            chk_out($sformatf("R5 gp%0d cleared", i), 0);
            rd(3, v); check("R5 pend cleared", v, 0);
          end else begin
            chk_out($sformatf("R3 gp%0d p%0d released", i, p), 0);
          end
        end
      end
    end
    wr(0, 0);

    // R9 R10 mask sweep with all sources pending
    kb_row = 8'hFE; pen_down_n = 1'b0; gp_pin = 4'hF;
    wr(1, 'h00F0);
    wr(4, 'h0075);
    wr(0, 'h1F01);
    for (int m = 0; m < 64; m++) begin
      int lv [6];
      int exp;
      lv = '{5, 7, 6, 3, 2, 1};
      wr(2, m);
      tick(3);
      exp = 0;
      for (int s = 0; s < 6; s++)
        if (!m[s] && lv[s] > exp) exp = lv[s];
      chk_out($sformatf("R10 mask %0d", m), exp);
      if (m == 63) begin
        rd(3, v); check("R9 masked still pending", v, 'h3F);
      end
    end

    // R6 R10 subsets of general pins, keyboard and pen masked
    wr(2, 'h03);
    for (int s = 0; s < 16; s++) begin
      int exp;
      gp_pin = 4'(s);
      tick(4);
      exp = 0;
      for (int b = 0; b < 4; b++)
        if (s[b] && gp_lv[b] > exp) exp = gp_lv[b];
      chk_out($sformatf("R6 subset %0d", s), exp);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule